// File: doc/BRIEF.md
# Quad double-buffered DAC register bank

This block holds the digital state of a four-channel, 16-bit converter driven from a parallel host bus. Each channel has two registers: an input register that the host writes and can read back, and a DAC register whose value goes to the converter. A host cycle opens with chip select going low. The 2-bit address picks one input register, and the read/write line picks the direction. A write is committed when chip select returns high. It uses the address and data last seen while chip select was low. A read drives the addressed input register toward the data bus, and the bus enable is high only for the duration of that read.

Two pins arrive from outside the clock domain, and each is passed through a two-flop synchronizer. The load pin's rising edge copies all four input registers into the DAC registers in the same cycle, and holding the pin high has no further effect. The clear pin's rising edge sets both ranks of every channel to mid-scale (8000h) or to zero. A select pin, synchronized alongside it, picks between the two values. A clear wins over a load or a write commit that lands in the same cycle. The synchronous system reset brings every register to 0000h.

Top module: `quad_dac_regbank`

## Requirements
- R1: With cs_n low and rd_wr low, the word on data_in is stored into the input register chosen by addr (00 = channel 0, 01 = channel 1, 10 = channel 2, 11 = channel 3) at the first clock edge where cs_n is seen high again. The address and data used are those sampled at the last edge where cs_n was low, and at most one input register changes per cycle.
- R2: A write commit changes no DAC register and no other channel's input register.
- R3: While cs_n is low and rd_wr is high, data_out shows the addressed input register, and data_oe is 1, one clock after each sampled address.
- R4: data_oe is 0 one clock after any edge where cs_n is high or rd_wr is low.
- R5: When load_req is first seen high at a clock edge, every DAC register takes its input register's value at the third edge counting that one. Channel i appears on dac_vals[16*i+15 : 16*i].
- R6: While load_req stays high after its rising edge, the DAC registers hold, even when input registers are rewritten.
- R7: A rising edge on clr_req, with the same three-edge timing, sets all input and DAC registers to 8000h if clr_mid was high when clr_req was first seen high, or to 0000h if clr_mid was low.
- R8: A clear takes priority over a load edge or a write commit landing in the same cycle.
- R9: After the synchronous reset rst, every input and DAC register reads 0000h and data_oe is 0.
- R10: A host cycle with rd_wr high when cs_n returns high writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, all registers to 0000h |
| cs_n | input | 1 | Active-low chip select |
| rd_wr | input | 1 | 1 = read back, 0 = write |
| addr | input | 2 | Input register select |
| data_in | input | 16 | Write data from the host bus |
| data_out | output | 16 | Readback data toward the bus driver |
| data_oe | output | 1 | Bus driver enable; bus is high impedance when 0 |
| load_req | input | 1 | Asynchronous load pin, rising edge copies input rank to DAC rank |
| clr_req | input | 1 | Asynchronous clear pin, rising edge clears both ranks |
| clr_mid | input | 1 | Clear target: 1 = 8000h, 0 = 0000h |
| dac_vals | output | 64 | DAC register values, channel i at bits 16*i+15:16*i |

## Verification
The bench rewrites an input register while the load pin is held high. A design that copies on the level rather than on the edge would then change a DAC output too early. It also sets up a clear edge that lands exactly on a write commit, and one that lands on a load edge. Wrong priority there shows up as the written word, or the pre-clear input values, surviving in place of the clear value. Read cycles that end with chip select rising confirm that a read is not mistaken for a write, and the reference model catches a synchronizer with the wrong depth by the one-cycle shift in when the DAC outputs change.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int unsigned QDR_DW  = 16;
  localparam int unsigned QDR_NCH = 4;
  localparam int unsigned QDR_SYNC = 2;

  typedef enum logic {
    CLR_TO_ZERO = 1'b0,
    CLR_TO_MID  = 1'b1
  } clr_target_e;
endpackage

// File: rtl/qdr_edge_sync.sv
module qdr_edge_sync #(
  parameter int unsigned LANES  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [LANES-1:0] EDGE_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] pin_in,
  output logic [LANES-1:0] ev_o
);
  // pipe[0..STAGES-1] is the synchronizer chain, pipe[STAGES] the previous value
  logic [LANES-1:0] pipe [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= pin_in;
      for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (EDGE_MASK[g]) begin : g_edge
      assign ev_o[g] = pipe[STAGES-1][g] & ~pipe[STAGES][g];
      // an edge lane gives one pulse per rising edge, never two in a row (R6)
      p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        ev_o[g] |=> !ev_o[g]);
    end else begin : g_level
      assign ev_o[g] = pipe[STAGES-1][g];
    end
  end
endmodule

// File: rtl/qdr_host_if.sv
module qdr_host_if #(
  parameter int unsigned DW  = 16,
  parameter int unsigned NCH = 4,
  localparam int unsigned AW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_wr,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     data_in,
  input  logic [NCH*DW-1:0] in_flat,
  output logic [NCH-1:0]    wr_en,
  output logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     data_out,
  output logic              data_oe
);
  logic          cs_q;
  logic          lat_wr;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_data;
  logic          commit;
  logic          rd_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= 1'b1;
      lat_wr   <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      cs_q <= cs_n;
      if (!cs_n) begin
        lat_addr <= addr;
        lat_data <= data_in;
        lat_wr   <= ~rd_wr;
      end
    end
  end

  assign commit  = cs_n & ~cs_q & lat_wr;
  assign wr_data = lat_data;

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign wr_en[i] = commit && (lat_addr == AW'(i));
  end

  assign rd_now = ~cs_n & rd_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      data_oe  <= rd_now;
      data_out <= rd_now ? in_flat[int'(addr)*DW +: DW] : '0;
    end
  end

  p_oe_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (cs_n || !rd_wr) |=> !data_oe);
  p_one_commit_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));
  p_read_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && rd_wr) |=> (wr_en == '0));
endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank
  import qdr_pkg::*;
#(
  parameter int unsigned DW     = QDR_DW,
  parameter int unsigned NCH    = QDR_NCH,
  parameter int unsigned STAGES = QDR_SYNC,
  localparam int unsigned AW    = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_wr,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     data_in,
  output logic [DW-1:0]     data_out,
  output logic              data_oe,
  input  logic              load_req,
  input  logic              clr_req,
  input  logic              clr_mid,
  output logic [NCH*DW-1:0] dac_vals
);
  localparam logic [DW-1:0] MID_CODE = DW'(1) << (DW-1);

  logic [2:0]      sync_ev;
  logic            ld_rise;
  logic            clr_rise;
  clr_target_e     clr_tgt;
  logic [DW-1:0]   clr_val;
  logic [NCH-1:0]  wr_en;
  logic [DW-1:0]   wr_data;
  logic [NCH*DW-1:0] in_flat;
  logic [DW-1:0]   in_q  [NCH];
  logic [DW-1:0]   dac_q [NCH];

  qdr_edge_sync #(
    .LANES(3), .STAGES(STAGES), .EDGE_MASK(3'b011)
  ) u_sync (
    .clk(clk), .rst(rst),
    .pin_in({clr_mid, clr_req, load_req}),
    .ev_o(sync_ev)
  );

  assign ld_rise  = sync_ev[0];
  assign clr_rise = sync_ev[1];
  assign clr_tgt  = clr_target_e'(sync_ev[2]);
  assign clr_val  = (clr_tgt == CLR_TO_MID) ? MID_CODE : '0;

  qdr_host_if #(.DW(DW), .NCH(NCH)) u_host (
    .clk(clk), .rst(rst),
    .cs_n(cs_n), .rd_wr(rd_wr), .addr(addr), .data_in(data_in),
    .in_flat(in_flat),
    .wr_en(wr_en), .wr_data(wr_data),
    .data_out(data_out), .data_oe(data_oe)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)            in_q[i] <= '0;
      else if (clr_rise)  in_q[i] <= clr_val;
      else if (wr_en[i])  in_q[i] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst)            dac_q[i] <= '0;
      else if (clr_rise)  dac_q[i] <= clr_val;
      else if (ld_rise)   dac_q[i] <= in_q[i];
    end

    assign in_flat[i*DW +: DW]  = in_q[i];
    assign dac_vals[i*DW +: DW] = dac_q[i];
  end

  p_dac_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!ld_rise && !clr_rise) |=> $stable(dac_vals));
  p_load_copy_r5: assert property (@(posedge clk) disable iff (rst)
    (ld_rise && !clr_rise) |=> (dac_vals == $past(in_flat)));
  p_clear_fill_r7: assert property (@(posedge clk) disable iff (rst)
    clr_rise |=> (dac_vals == {NCH{$past(clr_val)}}));
  p_clear_beats_write_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_rise && (wr_en != '0)) |=> (in_flat == {NCH{$past(clr_val)}}));
endmodule

// File: tb/quad_dac_regbank_tb.sv
`timescale 1ns/1ps
module quad_dac_regbank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        rd_wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] data_in = '0;
  logic        load_req = 1'b0;
  logic        clr_req = 1'b0;
  logic        clr_mid = 1'b0;
  logic [15:0] data_out;
  logic        data_oe;
  logic [63:0] dac_vals;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_req = "R9";

  always #2 clk = ~clk;

  quad_dac_regbank u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_wr(rd_wr), .addr(addr),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .load_req(load_req), .clr_req(clr_req), .clr_mid(clr_mid),
    .dac_vals(dac_vals)
  );

  // behavioural reference model
  int unsigned m_in [4];
  int unsigned m_dac [4];
  int unsigned m_out;
  bit          m_oe;
  bit          ldh [4];
  bit          clh [4];
  bit          slh [4];
  bit          cs_prev;
  bit          l_wr;
  int unsigned l_addr;
  int unsigned l_data;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_in[i] = 0; m_dac[i] = 0; ldh[i] = 0; clh[i] = 0; slh[i] = 0;
      end
      m_out = 0; m_oe = 0; cs_prev = 1; l_wr = 0; l_addr = 0; l_data = 0;
    end else begin
      bit ld_r, cl_r, commit;
      int unsigned fill;
      for (int j = 3; j > 0; j--) begin
        ldh[j] = ldh[j-1]; clh[j] = clh[j-1]; slh[j] = slh[j-1];
      end
      ldh[0] = load_req; clh[0] = clr_req; slh[0] = clr_mid;
      ld_r = ldh[2] && !ldh[3];
      cl_r = clh[2] && !clh[3];
      fill = slh[2] ? 32'h8000 : 32'h0;
      commit = cs_n && !cs_prev && l_wr;
      m_oe  = !cs_n && rd_wr;
      m_out = m_oe ? m_in[addr] : 0;
      for (int i = 0; i < 4; i++) begin
        if (cl_r) m_dac[i] = fill;
        else if (ld_r) m_dac[i] = m_in[i];
      end
      if (cl_r) begin
        for (int i = 0; i < 4; i++) m_in[i] = fill;
      end else if (commit) begin
        m_in[l_addr] = l_data;
      end
      if (!cs_n) begin
        l_addr = addr; l_data = data_in; l_wr = !rd_wr;
      end
      cs_prev = cs_n;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit ok;
      ok = (data_oe == m_oe) && (!m_oe || data_out == m_out[15:0]);
      for (int i = 0; i < 4; i++)
        if (dac_vals[i*16 +: 16] != m_dac[i][15:0]) ok = 0;
      n_chk++;
      if (!ok) begin
        n_bad++;
        $display("FAIL %s model compare: dac=%h oe=%b out=%h expected dac=%h%h%h%h oe=%b out=%h",
                 cur_req, dac_vals, data_oe, data_out, m_dac[3][15:0], m_dac[2][15:0],
                 m_dac[1][15:0], m_dac[0][15:0], m_oe, m_out[15:0]);
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] chan(input int i);
    return dac_vals[i*16 +: 16];
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ch, input logic [15:0] v);
    @(negedge clk); cs_n = 0; rd_wr = 0; addr = 2'(ch); data_in = v;
    @(negedge clk); cs_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(input int ch, output logic [15:0] v, output logic oe);
    @(negedge clk); cs_n = 0; rd_wr = 1; addr = 2'(ch);
    @(negedge clk); v = data_out; oe = data_oe; cs_n = 1; rd_wr = 0;
    @(negedge clk);
  endtask

  task automatic pulse_ld();
    @(negedge clk); load_req = 1;
    idle(3); load_req = 0;
    idle(4);
  endtask

  task automatic pulse_clr(input logic sel);
    @(negedge clk); clr_req = 1; clr_mid = sel;
    idle(3); clr_req = 0;
    idle(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic oe;
    logic [15:0] wv [4];
    wv[0] = 16'h1234; wv[1] = 16'hABCD; wv[2] = 16'h0001; wv[3] = 16'hFFFF;

    idle(5); rst = 0; idle(2);
    cur_req = "R9";
    for (int i = 0; i < 4; i++) chk("R9 dac after reset", chan(i), 16'h0000);
    chk("R9 oe after reset", {15'd0, data_oe}, 16'h0000);
    rd(0, v, oe); chk("R9 input after reset", v, 16'h0000);

    cur_req = "R1";
    for (int i = 0; i < 4; i++) wr(i, wv[i]);
    cur_req = "R3";
    for (int i = 0; i < 4; i++) begin
      rd(i, v, oe);
      chk("R1 R3 readback", v, wv[i]);
      chk("R3 oe during read", {15'd0, oe}, 16'h0001);
    end
    cur_req = "R2";
    for (int i = 0; i < 4; i++) chk("R2 dac held after writes", chan(i), 16'h0000);

    cur_req = "R4";
    @(negedge clk); cs_n = 0; rd_wr = 0; addr = 2'd1; data_in = wv[1];
    @(negedge clk); chk("R4 oe during write", {15'd0, data_oe}, 16'h0000);
    cs_n = 1;
    @(negedge clk); chk("R4 oe with cs high", {15'd0, data_oe}, 16'h0000);

    cur_req = "R5";
    pulse_ld();
    for (int i = 0; i < 4; i++) chk("R5 dac after load", chan(i), wv[i]);

    cur_req = "R6";
    @(negedge clk); load_req = 1;
    idle(4);
    wr(0, 16'h5A5A);
    idle(3);
    chk("R6 dac holds while load high", chan(0), 16'h1234);
    load_req = 0;
    idle(3);
    pulse_ld();
    chk("R6 dac after new load edge", chan(0), 16'h5A5A);

    cur_req = "R10";
    @(negedge clk); cs_n = 0; rd_wr = 1; addr = 2'd1; data_in = 16'hDEAD;
    @(negedge clk); cs_n = 1;
    idle(2); rd_wr = 0;
    rd(1, v, oe); chk("R10 read cycle did not write", v, 16'hABCD);

    cur_req = "R7";
    pulse_clr(1'b1);
    for (int i = 0; i < 4; i++) chk("R7 dac cleared to mid", chan(i), 16'h8000);
    rd(2, v, oe); chk("R7 input cleared to mid", v, 16'h8000);
    pulse_clr(1'b0);
    for (int i = 0; i < 4; i++) chk("R7 dac cleared to zero", chan(i), 16'h0000);
    rd(3, v, oe); chk("R7 input cleared to zero", v, 16'h0000);

    cur_req = "R8";
    for (int i = 0; i < 4; i++) wr(i, wv[i]);
    @(negedge clk); load_req = 1; clr_req = 1; clr_mid = 1;
    idle(3); load_req = 0; clr_req = 0;
    idle(4);
    for (int i = 0; i < 4; i++) chk("R8 clear beats load", chan(i), 16'h8000);
    wr(0, 16'h7777);
    @(negedge clk); clr_req = 1; clr_mid = 0; cs_n = 0; rd_wr = 0; addr = 2'd0; data_in = 16'h3333;
    @(negedge clk);
    @(negedge clk); cs_n = 1;
    idle(2); clr_req = 0;
    idle(3);
    rd(0, v, oe); chk("R8 clear beats write commit", v, 16'h0000);
    rd(1, v, oe); chk("R8 other channel cleared", v, 16'h0000);

    idle(3);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule